// File: doc/BRIEF.md
# Sixteen-Bit Multi-Cycle Accumulator Processor Core

This block is a small 16-bit processor core that runs one fixed-length 16-bit instruction word at a time. Program and data share a single word-addressed memory of 4096 words. The memory sits outside the core and is read combinationally. The core drives a 12-bit address, a 16-bit write-data bus and a write strobe, and it takes a separate 16-bit read-data bus back. Each instruction passes through four states: fetch, decode, execute and writeback. So every instruction occupies exactly four clock cycles, and a data access is made in the execute state.

Architectural state is held in four places: eight 16-bit general registers (RA to RH, indices 0 to 7), a 12-bit program counter, a two-flag status register (zero and carry), and a private four-entry return-address LIFO that serves subroutine calls. The arithmetic and logic datapath is a separate instantiated unit. Addresses 0x0D and 0x0E in the primary opcode space, and the unused secondary codes, are reserved. They behave as no-ops, which leaves room to extend the instruction set later.

A call issued while the LIFO is full, or a return issued while it is empty, sets a sticky error output. The stack pointer still wraps modulo four in both cases.

Top module: `cpu16_core`

## Requirements
- R1: When rst_n is released, the core fetches its first instruction from address 0, mem_we is low and stack_err is low.
- R2: Word fields are fixed as follows: primary opcode in bits 15:12, absolute/direct address in 11:0, destination RX in 10:8, immediate KK in 7:0, source RY in 6:4 and secondary opcode in 3:0. Immediate move (0x0), add (0x1) and subtract (0x2) sign-extend KK. Immediate AND (0x3) zero-extends KK.
- R3: The absolute forms always use RA as their register operand. These are load (0x4, RA<-M), store (0x5, M<-RA), addm (0x6, RA+=M) and subm (0x7, RA-=M). Other registers are left unchanged.
- R4: Under primary opcode 0xF, the secondary codes are: 0x1 register move RX<-RY, 0x2 indirect load RX<-M[RY], 0x3 indirect store M[RY]<-RX, 0x4 rotate RX left by one, and 0xA RX<-RX xor RY.
- R5: The arithmetic, logic and rotate instructions update the flags, and every other instruction leaves them unchanged. Z is set when the result is zero. C is the carry-out for add, the borrow for subtract, and the bit rotated out for rotate. C is cleared for AND and XOR.
- R6: Opcode 0x8 always jumps to the 12-bit target. Opcode 0x9 jumps when Z=1, 0xA jumps when Z=0 and 0xB jumps when C=1. When the condition fails, the PC advances by one.
- R7: Call (0xC) pushes PC+1 and jumps to the target. Return (0xF with secondary 0x0) pops the most recent entry into the PC. Calls nest correctly to a depth of four.
- R8: A fifth outstanding call, or a return with the LIFO empty, sets stack_err. stack_err stays set until reset. The pointer wraps modulo four, so after an overflow the newest return address is the one popped first.
- R9: Primary opcodes 0xD and 0xE, and the secondary codes 0x5 to 0x9 and 0xB to 0xF, change no register, flag or memory word and advance the PC by one.
- R10: Every instruction takes exactly four cycles. A store asserts mem_we for exactly one cycle, with the address and data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Word address for instruction fetch or data access |
| mem_rdata | input | 16 | Combinational read data from memory |
| mem_wdata | output | 16 | Write data for stores |
| mem_we | output | 1 | Write strobe, one cycle per store |
| stack_err | output | 1 | Sticky return-LIFO overflow/underflow indication |

## Verification
The flags have no port of their own, so the hardest state to observe is the pair left behind by one instruction and then consumed by a later conditional jump. The bench handles this with a probe sequence. First a flag-neutral immediate move loads a result address. Then a conditional jump selects which of two constants is written to that address through an indirect store. This turns each flag state into a memory word, and it also checks that the intervening moves and loads did not disturb the flags. The LIFO overflow is reached with a chain of five nested calls. The innermost routine returns at once, and the path it lands on shows the wrap order.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the 16-bit core.
// Assumes the fixed 16-bit instruction encoding; widths below follow from it.
package cpu16_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 12;
    localparam int REG_AW   = 3;
    localparam int NUM_REGS = 1 << REG_AW;
    localparam int IMM_W    = 8;

    // primary opcodes
    localparam logic [3:0] OP_MOVI  = 4'h0;
    localparam logic [3:0] OP_ADDI  = 4'h1;
    localparam logic [3:0] OP_SUBI  = 4'h2;
    localparam logic [3:0] OP_ANDI  = 4'h3;
    localparam logic [3:0] OP_LDA   = 4'h4;
    localparam logic [3:0] OP_STA   = 4'h5;
    localparam logic [3:0] OP_ADDM  = 4'h6;
    localparam logic [3:0] OP_SUBM  = 4'h7;
    localparam logic [3:0] OP_JMP   = 4'h8;
    localparam logic [3:0] OP_JZ    = 4'h9;
    localparam logic [3:0] OP_JNZ   = 4'hA;
    localparam logic [3:0] OP_JC    = 4'hB;
    localparam logic [3:0] OP_CALL  = 4'hC;
    localparam logic [3:0] OP_GROUP = 4'hF;

    // secondary opcodes under OP_GROUP
    localparam logic [3:0] SUB_RET  = 4'h0;
    localparam logic [3:0] SUB_MOV  = 4'h1;
    localparam logic [3:0] SUB_LDI  = 4'h2;
    localparam logic [3:0] SUB_STI  = 4'h3;
    localparam logic [3:0] SUB_ROL  = 4'h4;
    localparam logic [3:0] SUB_XOR  = 4'hA;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_WB     = 2'd3
    } state_e;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_XOR, ALU_ROL
    } alu_op_e;

    typedef enum logic [1:0] {
        B_IMM_S, B_IMM_Z, B_MEM, B_OPY
    } bsel_e;

    typedef enum logic [1:0] {
        CND_ALWAYS, CND_Z, CND_NZ, CND_C
    } cond_e;

    typedef struct packed {
        alu_op_e alu_op;
        bsel_e   b_sel;
        logic    wr_reg;
        logic    a_is_ra;
        logic    set_flags;
        logic    mem_rd;
        logic    mem_wr;
        logic    indirect;
        logic    jmp;
        cond_e   cond;
        logic    call;
        logic    ret;
    } ctl_t;

endpackage

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
// Arithmetic/logic unit: combinational, produces result, zero and carry.
// Assumes subtract reports borrow in the carry output.
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic         z_o,
    output logic         c_o
);

    logic [W:0] wide;

    // Select the operation and the carry source.
    always_comb begin
        wide = '0;
        unique case (op_i)
            ALU_ADD:  wide = {1'b0, a_i} + {1'b0, b_i};
            ALU_SUB:  wide = {1'b0, a_i} - {1'b0, b_i};
            ALU_AND:  wide = {1'b0, a_i & b_i};
            ALU_XOR:  wide = {1'b0, a_i ^ b_i};
            ALU_ROL:  wide = {a_i[W-1], a_i[W-2:0], a_i[W-1]};
            default:  wide = {1'b0, b_i};
        endcase
    end

    assign y_o = wide[W-1:0];
    assign c_o = wide[W];
    assign z_o = (wide[W-1:0] == '0);

endmodule

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
// General register file: N registers, two combinational read ports, one write port.
// Assumes a single write per cycle; all registers clear on reset.
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int N  = NUM_REGS,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [W-1:0]  rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_b_o
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Hold one register; load it when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we_i && (waddr_i == AW'(g))) begin
                regs[g] <= wdata_i;
            end
        end
    end

    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/cpu16_retstack.sv
`timescale 1ns/1ps
// Private return-address LIFO with a wrapping pointer and sticky misuse flag.
// Assumes DEPTH is a power of two; push and pop are never asserted together.
module cpu16_retstack #(
    parameter int W     = 12,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o,
    output logic         err_o
);

    logic [W-1:0]  entry [DEPTH];
    logic [PW-1:0] sp_q;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold one slot; written by a push aimed at it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (push_i && (sp_q == PW'(g))) begin
                entry[g] <= push_data_i;
            end
        end
    end

    // Move the pointer, track occupancy and latch misuse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (push_i) begin
            sp_q <= sp_q + 1'b1;
            if (cnt_q == CW'(DEPTH)) err_q <= 1'b1;
            else                     cnt_q <= cnt_q + 1'b1;
        end else if (pop_i) begin
            sp_q <= sp_q - 1'b1;
            if (cnt_q == '0) err_q <= 1'b1;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign top_o = entry[sp_q - 1'b1];
    assign err_o = err_q;

endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
// Multi-cycle 16-bit processor core: fetch, decode, execute, writeback.
// Assumes memory answers reads combinationally in the same cycle as mem_addr.
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              stack_err
);

    localparam int EXT_W = DATA_W - IMM_W;

    state_e            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] opx_q, opy_q, res_q;
    logic              res_z_q, res_c_q;
    logic              flag_z_q, flag_c_q;

    logic [3:0]        f_op, f_sub;
    logic [REG_AW-1:0] f_rx, f_ry, rd_sel, dst;
    logic [IMM_W-1:0]  f_kk;
    logic [ADDR_W-1:0] f_abs;
    ctl_t              ctl;

    logic [DATA_W-1:0] rd_a, rd_b, alu_b, alu_y;
    logic              alu_z, alu_c;
    logic              taken;
    logic [ADDR_W-1:0] pc_inc, pc_nxt, stk_top;
    logic              in_wb, in_exec;

    assign f_op  = ir_q[15:12];
    assign f_abs = ir_q[ADDR_W-1:0];
    assign f_rx  = ir_q[10:8];
    assign f_kk  = ir_q[IMM_W-1:0];
    assign f_ry  = ir_q[6:4];
    assign f_sub = ir_q[3:0];

    assign in_wb   = (state_q == ST_WB);
    assign in_exec = (state_q == ST_EXEC);

    // Translate the instruction word into datapath controls.
    always_comb begin
        ctl = '{alu_op: ALU_PASS, b_sel: B_IMM_S, cond: CND_ALWAYS, default: 1'b0};
        unique case (f_op)
            OP_MOVI: begin ctl.wr_reg = 1'b1; end
            OP_ADDI: begin ctl.alu_op = ALU_ADD; ctl.wr_reg = 1'b1; ctl.set_flags = 1'b1; end
            OP_SUBI: begin ctl.alu_op = ALU_SUB; ctl.wr_reg = 1'b1; ctl.set_flags = 1'b1; end
            OP_ANDI: begin
                ctl.alu_op = ALU_AND; ctl.b_sel = B_IMM_Z;
                ctl.wr_reg = 1'b1;    ctl.set_flags = 1'b1;
            end
            OP_LDA: begin
                ctl.b_sel = B_MEM; ctl.a_is_ra = 1'b1;
                ctl.mem_rd = 1'b1; ctl.wr_reg = 1'b1;
            end
            OP_STA: begin ctl.a_is_ra = 1'b1; ctl.mem_wr = 1'b1; end
            OP_ADDM, OP_SUBM: begin
                ctl.alu_op    = (f_op == OP_ADDM) ? ALU_ADD : ALU_SUB;
                ctl.b_sel     = B_MEM;  ctl.a_is_ra = 1'b1;
                ctl.mem_rd    = 1'b1;   ctl.wr_reg  = 1'b1;
                ctl.set_flags = 1'b1;
            end
            OP_JMP: begin ctl.jmp = 1'b1; ctl.cond = CND_ALWAYS; end
            OP_JZ:  begin ctl.jmp = 1'b1; ctl.cond = CND_Z; end
            OP_JNZ: begin ctl.jmp = 1'b1; ctl.cond = CND_NZ; end
            OP_JC:  begin ctl.jmp = 1'b1; ctl.cond = CND_C; end
            OP_CALL: begin ctl.call = 1'b1; end
            OP_GROUP: begin
                unique case (f_sub)
                    SUB_RET: ctl.ret = 1'b1;
                    SUB_MOV: begin ctl.b_sel = B_OPY; ctl.wr_reg = 1'b1; end
                    SUB_LDI: begin
                        ctl.b_sel  = B_MEM;  ctl.mem_rd = 1'b1;
                        ctl.indirect = 1'b1; ctl.wr_reg = 1'b1;
                    end
                    SUB_STI: begin ctl.mem_wr = 1'b1; ctl.indirect = 1'b1; end
                    SUB_ROL: begin ctl.alu_op = ALU_ROL; ctl.wr_reg = 1'b1; ctl.set_flags = 1'b1; end
                    SUB_XOR: begin
                        ctl.alu_op = ALU_XOR; ctl.b_sel = B_OPY;
                        ctl.wr_reg = 1'b1;    ctl.set_flags = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    assign rd_sel = ctl.a_is_ra ? '0 : f_rx;
    assign dst    = rd_sel;

    cpu16_regfile #(
        .W (DATA_W),
        .N (NUM_REGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (in_wb && ctl.wr_reg),
        .waddr_i   (dst),
        .wdata_i   (res_q),
        .raddr_a_i (rd_sel),
        .rdata_a_o (rd_a),
        .raddr_b_i (f_ry),
        .rdata_b_o (rd_b)
    );

    // Pick the second ALU operand.
    always_comb begin
        unique case (ctl.b_sel)
            B_IMM_Z: alu_b = {{EXT_W{1'b0}}, f_kk};
            B_MEM:   alu_b = mem_rdata;
            B_OPY:   alu_b = opy_q;
            default: alu_b = {{EXT_W{f_kk[IMM_W-1]}}, f_kk};
        endcase
    end

    cpu16_alu #(
        .W (DATA_W)
    ) u_alu (
        .a_i  (opx_q),
        .b_i  (alu_b),
        .op_i (ctl.alu_op),
        .y_o  (alu_y),
        .z_o  (alu_z),
        .c_o  (alu_c)
    );

    cpu16_retstack #(
        .W     (ADDR_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (in_wb && ctl.call),
        .pop_i       (in_wb && ctl.ret),
        .push_data_i (pc_inc),
        .top_o       (stk_top),
        .err_o       (stack_err)
    );

    // Evaluate the branch condition against the stored flags.
    always_comb begin
        unique case (ctl.cond)
            CND_Z:   taken = flag_z_q;
            CND_NZ:  taken = !flag_z_q;
            CND_C:   taken = flag_c_q;
            default: taken = 1'b1;
        endcase
    end

    // Choose the next program counter.
    always_comb begin
        pc_inc = pc_q + 1'b1;
        pc_nxt = pc_inc;
        if ((ctl.jmp && taken) || ctl.call) pc_nxt = f_abs;
        if (ctl.ret)                        pc_nxt = stk_top;
    end

    // Step the four-state sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            unique case (state_q)
                ST_FETCH:  state_q <= ST_DECODE;
                ST_DECODE: state_q <= ST_EXEC;
                ST_EXEC:   state_q <= ST_WB;
                default:   state_q <= ST_FETCH;
            endcase
        end
    end

    // Capture the instruction word and the register operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            opx_q <= '0;
            opy_q <= '0;
        end else if (state_q == ST_FETCH) begin
            ir_q <= mem_rdata;
        end else if (state_q == ST_DECODE) begin
            opx_q <= rd_a;
            opy_q <= rd_b;
        end
    end

    // Hold the execute result until writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            res_z_q <= 1'b0;
            res_c_q <= 1'b0;
        end else if (in_exec) begin
            res_q   <= alu_y;
            res_z_q <= alu_z;
            res_c_q <= alu_c;
        end
    end

    // Commit program counter and status flags at writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            flag_z_q <= 1'b0;
            flag_c_q <= 1'b0;
        end else if (in_wb) begin
            pc_q <= pc_nxt;
            if (ctl.set_flags) begin
                flag_z_q <= res_z_q;
                flag_c_q <= res_c_q;
            end
        end
    end

    assign mem_addr  = (in_exec && (ctl.mem_rd || ctl.mem_wr))
                     ? (ctl.indirect ? opy_q[ADDR_W-1:0] : f_abs)
                     : pc_q;
    assign mem_wdata = opx_q;
    assign mem_we    = in_exec && ctl.mem_wr;

endmodule

// File: rtl/cpu16_core_chk.sv
`timescale 1ns/1ps
// Property checker for cpu16_core; attached by bind below.
// Assumes it observes the sequencer state and the two status flags.
module cpu16_core_chk
    import cpu16_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              stack_err,
    input state_e            state_q,
    input logic              flag_z_q,
    input logic              flag_c_q
);

    AST_FIRST_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_addr == '0 && state_q == ST_FETCH)); // R1

    AST_FLAGS_WB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WB) |=> ($stable(flag_z_q) && $stable(flag_c_q))); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err); // R8

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R10

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R10

endmodule

bind cpu16_core cpu16_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .stack_err (stack_err),
    .state_q   (state_q),
    .flag_z_q  (flag_z_q),
    .flag_c_q  (flag_c_q)
);

// File: tb/cpu16_core_tb_top.sv
`timescale 1ns/1ps
// Directed bench: each task loads a small program, runs it and checks memory/ports.
module cpu16_core_tb_top;

    localparam int MEMW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata, mem_wdata;
    logic        mem_we, stack_err;

    logic [15:0] mem [MEMW];
    logic        ld_we = 1'b0;
    logic [9:0]  ld_a = '0;
    logic [15:0] ld_d = '0;
    int          checks = 0;
    int          errors = 0;
    int          we_cnt = 0;
    int          ap = 0;

    always #10 clk = ~clk;

    cpu16_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .stack_err (stack_err)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (ld_we)       mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end

    always @(negedge clk) if (rst_n && mem_we) we_cnt++;

    // encoders
    function automatic logic [15:0] ei(input logic [3:0] op, input logic [2:0] rx, input logic [7:0] kk);
        return {op, 1'b0, rx, kk};
    endfunction
    function automatic logic [15:0] ea(input logic [3:0] op, input logic [11:0] ad);
        return {op, ad};
    endfunction
    function automatic logic [15:0] er(input logic [2:0] rx, input logic [2:0] ry, input logic [3:0] sb);
        return {4'hF, 1'b0, rx, 1'b0, ry, sb};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] d);
        ld_a = 10'(a); ld_d = d; ld_we = 1'b1;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic emit(input logic [15:0] w);
        put(ap, w);
        ap++;
    endtask

    task automatic begin_prog();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < MEMW; i++) put(i, 16'h0);
        ap = 0;
    endtask

    task automatic run(input int n);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic halt();
        emit(ea(4'h8, 12'(ap)));
    endtask

    // probe: records 1/0 at M[slot] depending on whether jump op is taken
    task automatic probe(input logic [3:0] jop, input logic [7:0] slot);
        int p;
        emit(ei(4'h0, 3'd7, slot));
        p = ap;
        emit(ea(jop, 12'(p + 3)));
        emit(ei(4'h0, 3'd6, 8'd0));
        emit(ea(4'h8, 12'(p + 4)));
        emit(ei(4'h0, 3'd6, 8'd1));
        emit(er(3'd6, 3'd7, 4'h3));
    endtask

    task automatic t_reset();
        begin_prog();
        emit(ei(4'h0, 3'd0, 8'd1));
        halt();
        rst_n = 1'b1;
        check("R1 first fetch address", 16'(mem_addr), 16'h0);
        check("R1 write strobe idle", 16'(mem_we), 16'h0);
        check("R1 stack_err clear", 16'(stack_err), 16'h0);
        repeat (3) @(negedge clk);
        check("R10 pc held through writeback", 16'(mem_addr), 16'h0);
        @(negedge clk);
        check("R10 next fetch after four cycles", 16'(mem_addr), 16'h1);
    endtask

    task automatic t_immediate();
        begin_prog();
        emit(ei(4'h0, 3'd1, 8'hFD));
        emit(ei(4'h0, 3'd2, 8'd5));
        emit(ei(4'h1, 3'd2, 8'h7F));
        emit(ei(4'h2, 3'd2, 8'd2));
        emit(ei(4'h0, 3'd3, 8'hFF));
        emit(ei(4'h3, 3'd3, 8'h80));
        emit(ei(4'h0, 3'd4, 8'h80));
        emit(ei(4'h0, 3'd7, 8'd100));
        emit(er(3'd1, 3'd7, 4'h3));
        emit(ei(4'h1, 3'd7, 8'd1));
        emit(er(3'd2, 3'd7, 4'h3));
        emit(ei(4'h1, 3'd7, 8'd1));
        emit(er(3'd3, 3'd7, 4'h3));
        emit(ei(4'h1, 3'd7, 8'd1));
        emit(er(3'd4, 3'd7, 4'h3));
        halt();
        run(120);
        check("R2 move sign-extends", mem[100], 16'hFFFD);
        check("R2 add/sub immediate", mem[101], 16'd130);
        check("R2 and zero-extends", mem[102], 16'h0080);
        check("R2 move -128", mem[103], 16'hFF80);
    endtask

    task automatic t_absolute();
        int w0;
        begin_prog();
        put(200, 16'd1000);
        put(201, 16'd7);
        emit(ei(4'h0, 3'd1, 8'd9));
        emit(ea(4'h4, 12'd200));
        emit(ea(4'h6, 12'd201));
        emit(ea(4'h5, 12'd210));
        emit(ea(4'h7, 12'd200));
        emit(ea(4'h5, 12'd211));
        emit(ei(4'h0, 3'd7, 8'd120));
        emit(er(3'd1, 3'd7, 4'h3));
        halt();
        w0 = we_cnt;
        run(80);
        check("R3 load+addm into RA", mem[210], 16'd1007);
        check("R3 subm from RA", mem[211], 16'd7);
        check("R3 RB untouched", mem[120], 16'd9);
        check("R10 one strobe per store", 16'(we_cnt - w0), 16'd3);
    endtask

    task automatic t_register();
        begin_prog();
        put(300, 16'hBEEF);
        emit(ei(4'h0, 3'd2, 8'h40));
        emit(er(3'd2, 3'd0, 4'h4));
        emit(ei(4'h0, 3'd3, 8'h0F));
        emit(er(3'd3, 3'd2, 4'hA));
        emit(ei(4'h0, 3'd4, 8'h4B));
        emit(er(3'd4, 3'd0, 4'h4));
        emit(er(3'd4, 3'd0, 4'h4));
        emit(er(3'd5, 3'd4, 4'h2));
        emit(er(3'd6, 3'd5, 4'h1));
        emit(ei(4'h0, 3'd7, 8'd100));
        emit(er(3'd6, 3'd7, 4'h3));
        emit(ei(4'h1, 3'd7, 8'd1));
        emit(er(3'd2, 3'd7, 4'h3));
        emit(ei(4'h1, 3'd7, 8'd1));
        emit(er(3'd3, 3'd7, 4'h3));
        halt();
        run(120);
        check("R4 indirect load then move", mem[100], 16'hBEEF);
        check("R4 rotate left", mem[101], 16'h0080);
        check("R4 xor", mem[102], 16'h008F);
    endtask

    task automatic t_flags();
        begin_prog();
        put(200, 16'd5);
        emit(ei(4'h0, 3'd0, 8'd1));
        emit(ei(4'h2, 3'd0, 8'd1));
        probe(4'h9, 8'd112);
        probe(4'hB, 8'd113);
        probe(4'hA, 8'd114);
        emit(ei(4'h0, 3'd0, 8'hFF));
        emit(ei(4'h1, 3'd0, 8'd1));
        probe(4'hB, 8'd115);
        probe(4'h9, 8'd116);
        emit(ei(4'h0, 3'd0, 8'd0));
        emit(ei(4'h2, 3'd0, 8'd1));
        probe(4'hB, 8'd117);
        probe(4'hA, 8'd118);
        emit(ei(4'h3, 3'd0, 8'h0F));
        probe(4'hB, 8'd119);
        emit(ei(4'h0, 3'd1, 8'h80));
        emit(er(3'd1, 3'd0, 4'h4));
        probe(4'hB, 8'd120);
        emit(ei(4'h0, 3'd0, 8'd7));
        emit(ei(4'h2, 3'd0, 8'd7));
        emit(ei(4'h0, 3'd0, 8'd5));
        emit(ea(4'h4, 12'd200));
        emit(ea(4'h5, 12'd201));
        probe(4'h9, 8'd121);
        halt();
        run(600);
        check("R5 R6 jumpz taken on zero", mem[112], 16'd1);
        check("R5 R6 jumpc not taken, no borrow", mem[113], 16'd0);
        check("R6 jumpnz not taken on zero", mem[114], 16'd0);
        check("R5 add carry-out", mem[115], 16'd1);
        check("R5 add wrap to zero sets Z", mem[116], 16'd1);
        check("R5 subtract borrow", mem[117], 16'd1);
        check("R6 jumpnz taken on nonzero", mem[118], 16'd1);
        check("R5 and clears carry", mem[119], 16'd0);
        check("R5 rotate carries out msb", mem[120], 16'd1);
        check("R5 move/load/store keep flags", mem[121], 16'd1);
    endtask

    task automatic t_jump();
        begin_prog();
        emit(ei(4'h0, 3'd0, 8'h11));
        emit(ea(4'h8, 12'd3));
        emit(ei(4'h0, 3'd0, 8'h22));
        emit(ea(4'h5, 12'd400));
        halt();
        run(60);
        check("R6 unconditional jump skips", mem[400], 16'h0011);
    endtask

    task automatic t_call_ret();
        begin_prog();
        emit(ei(4'h0, 3'd0, 8'd0));
        emit(ea(4'hC, 12'd20));
        emit(ea(4'h5, 12'd500));
        halt();
        for (int s = 0; s < 3; s++) begin
            ap = 20 + 10 * s;
            emit(ei(4'h1, 3'd0, 8'd1));
            emit(ea(4'hC, 12'(30 + 10 * s)));
            emit(ei(4'h1, 3'd0, 8'h10));
            emit(er(3'd0, 3'd0, 4'h0));
        end
        ap = 50;
        emit(ei(4'h1, 3'd0, 8'd1));
        emit(er(3'd0, 3'd0, 4'h0));
        run(200);
        check("R7 four-deep nesting returns in order", mem[500], 16'h0034);
        check("R7 R8 no error at depth four", 16'(stack_err), 16'h0);
    endtask

    task automatic t_overflow();
        begin_prog();
        for (int s = 0; s < 5; s++) begin
            ap = 10 * s;
            emit(ea(4'hC, 12'(10 * s + 10)));
            if (s < 4) halt();
        end
        emit(ei(4'h0, 3'd0, 8'h55));
        emit(ea(4'h5, 12'd600));
        halt();
        ap = 50;
        emit(er(3'd0, 3'd0, 4'h0));
        run(150);
        check("R8 fifth call sets stack_err", 16'(stack_err), 16'h1);
        check("R8 wrapped pointer returns newest", mem[600], 16'h0055);
    endtask

    task automatic t_underflow();
        begin_prog();
        emit(er(3'd0, 3'd0, 4'h0));
        rst_n = 1'b1;
        check("R8 clear before return", 16'(stack_err), 16'h0);
        run(8);
        check("R8 return on empty sets error", 16'(stack_err), 16'h1);
        run(40);
        check("R8 error stays set", 16'(stack_err), 16'h1);
    endtask

    task automatic t_reserved();
        int w0;
        begin_prog();
        emit(ei(4'h0, 3'd0, 8'd3));
        emit(16'hD2BD);
        emit(16'hE2BD);
        emit(er(3'd0, 3'd1, 4'h5));
        emit(er(3'd0, 3'd1, 4'h9));
        emit(er(3'd0, 3'd1, 4'hB));
        emit(16'hFFFF);
        emit(ea(4'h9, 12'd0));
        emit(ea(4'h5, 12'd700));
        halt();
        w0 = we_cnt;
        run(80);
        check("R9 reserved codes leave RA and Z", mem[700], 16'd3);
        check("R9 reserved codes write nothing", mem[701], 16'd0);
        check("R9 single strobe only", 16'(we_cnt - w0), 16'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_immediate();
        t_absolute();
        t_register();
        t_flags();
        t_jump();
        t_call_ret();
        t_overflow();
        t_underflow();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule